// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Through Cache

This block sits between a CPU request port and a backing store that it holds in its own registers. The store has sixteen blocks of sixteen 16-bit words. The cache has eight lines of sixteen words, grouped in pairs into four sets. Line 2s and line 2s+1 make up set s. A block always lands in set (block number mod 4). Each line's tag holds the complete block number, so a hit needs a valid line in the mapped set whose tag equals the requested block number.

A request is a read of (block, offset) or a write of (block, offset, value), offered with a valid/ready handshake. A read miss copies the whole block into a line of the set and then returns the requested word. The line chosen is the first empty way, with way 0 before way 1. When both ways are valid, the low bit of a free-running 8-bit LFSR picks the way; the LFSR is seeded at reset. Every write goes to the backing store. The line is also updated when it holds the block, and a write miss allocates nothing. Four counters record read hits, read misses, write hits and write misses.

The controller is a four-state machine:
- CLEAR is entered on reset. It writes the reset pattern into the store one word per cycle and moves to IDLE after the last word.
- IDLE raises ready. On req_valid it latches the request and moves to LOOKUP.
- LOOKUP probes the set. A read hit or any write responds and returns to IDLE. A read miss moves to FILL.
- FILL loads the line, responds and returns to IDLE.

Top module: `wt_cache_2way`

## Requirements
- R1: After reset, req_ready stays low for exactly 256 rising edges while the store is loaded with word (b,o) = 16*b + o. All lines are invalid and all four counters read zero.
- R2: Block b maps to set b mod 4. Blocks that map to other sets never evict each other.
- R3: A read miss fills a line and answers with resp_hit=0 and the store's word. The response appears 2 rising edges after the accepting edge.
- R4: A read hit answers with resp_hit=1 and the cached word. The response appears 1 rising edge after the accepting edge.
- R5: Only a full tag match counts as a hit. Two blocks in the same set with different numbers never alias, and at most one way matches.
- R6: A fill uses the first invalid way of the set, way 0 first. If both ways are valid, exactly one of the two resident blocks is replaced, chosen by the low bit of a non-zero 8-bit LFSR.
- R7: A write hit updates both the line and the store word. A later read hits and returns the new value.
- R8: A write miss updates the store only and allocates nothing. A later read of that block misses and returns the new value.
- R9: Each request increments exactly one of the four counters, chosen by its kind (read or write) and its outcome (hit or miss).
- R10: req_ready is high only in IDLE and drops in the cycle after an accept. Each request gets exactly one single-cycle resp_valid pulse. For writes, resp_data echoes the written value and resp_hit reports the lookup result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_block | input | 4 | Memory block number |
| req_offset | input | 4 | Word offset within the block |
| req_wdata | input | 16 | Write value |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_data | output | 16 | Read word, or written value for writes |
| resp_hit | output | 1 | Lookup outcome of the answered request |
| cnt_rd_hit | output | 16 | Read hit count |
| cnt_rd_miss | output | 16 | Read miss count |
| cnt_wr_hit | output | 16 | Write hit count |
| cnt_wr_miss | output | 16 | Write miss count |

## Verification
A wrong tag or valid bit shows at the ports on the next request to the same set. resp_hit flips, and the response arrives one edge early or one edge late. A store word lost on the write-through path stays hidden while the line is resident. It only surfaces as wrong resp_data after an eviction forces a refill, so the sequence deliberately evicts and re-reads. A victim chosen in the wrong way is detected by probing both former residents with writes, which never allocate and so leave the set unchanged.

// File: rtl/wtc_pkg.sv
`timescale 1ns/1ps
package wtc_pkg;
    localparam int WAYS = 2;

    typedef enum logic [1:0] {
        ST_CLEAR,
        ST_IDLE,
        ST_LOOKUP,
        ST_FILL
    } wtc_state_e;
endpackage

// File: rtl/wtc_lfsr.sv
`timescale 1ns/1ps
module wtc_lfsr #(
    parameter logic [7:0] SEED = 8'hB7
) (
    input  logic clk,
    input  logic rst_n,
    output logic rnd_bit
);
    logic [7:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= SEED;
        else        sr_q <= {sr_q[6:0], sr_q[7] ^ sr_q[5] ^ sr_q[4] ^ sr_q[3]};
    end

    assign rnd_bit = sr_q[0];

    // R6: the random source never locks up at zero
    assert_lfsr_alive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sr_q != 8'h00);
endmodule

// File: rtl/wtc_set_probe.sv
`timescale 1ns/1ps
module wtc_set_probe #(
    parameter int BLK_W = 4
) (
    input  logic [1:0]       way_valid,
    input  logic [BLK_W-1:0] way0_tag,
    input  logic [BLK_W-1:0] way1_tag,
    input  logic [BLK_W-1:0] probe_block,
    input  logic             rnd_bit,
    output logic [1:0]       way_match,
    output logic             victim_way
);
    always_comb begin
        way_match[0] = way_valid[0] && (way0_tag == probe_block);
        way_match[1] = way_valid[1] && (way1_tag == probe_block);
        if (!way_valid[0])      victim_way = 1'b0;
        else if (!way_valid[1]) victim_way = 1'b1;
        else                    victim_way = rnd_bit;
    end
endmodule

// File: rtl/wtc_perf_counters.sv
`timescale 1ns/1ps
module wtc_perf_counters #(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CNT-1:0]            bump,
    output logic [NUM_CNT-1:0][CNT_W-1:0] count
);
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       count[i] <= '0;
            else if (bump[i]) count[i] <= count[i] + CNT_W'(1);
        end
    end

    // R9: a request touches at most one counter per cycle
    assert_one_counter_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bump));
endmodule

// File: rtl/wt_cache_2way.sv
`timescale 1ns/1ps
module wt_cache_2way #(
    parameter int         NUM_BLOCKS      = 16,
    parameter int         WORDS_PER_BLOCK = 16,
    parameter int         NUM_LINES       = 8,
    parameter int         DATA_W          = 16,
    parameter int         CNT_W           = 16,
    parameter logic [7:0] LFSR_SEED       = 8'hB7
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    output logic                            req_ready,
    input  logic                            req_write,
    input  logic [$clog2(NUM_BLOCKS)-1:0]   req_block,
    input  logic [$clog2(WORDS_PER_BLOCK)-1:0] req_offset,
    input  logic [DATA_W-1:0]               req_wdata,
    output logic                            resp_valid,
    output logic [DATA_W-1:0]               resp_data,
    output logic                            resp_hit,
    output logic [CNT_W-1:0]                cnt_rd_hit,
    output logic [CNT_W-1:0]                cnt_rd_miss,
    output logic [CNT_W-1:0]                cnt_wr_hit,
    output logic [CNT_W-1:0]                cnt_wr_miss
);
    import wtc_pkg::*;

    localparam int BLK_W     = $clog2(NUM_BLOCKS);
    localparam int OFF_W     = $clog2(WORDS_PER_BLOCK);
    localparam int LINE_W    = $clog2(NUM_LINES);
    localparam int SET_W     = LINE_W - 1;
    localparam int MEM_WORDS = NUM_BLOCKS * WORDS_PER_BLOCK;
    localparam int MEM_W     = BLK_W + OFF_W;

    wtc_state_e state_q, state_d;

    logic             q_write;
    logic [BLK_W-1:0] q_block;
    logic [OFF_W-1:0] q_off;
    logic [DATA_W-1:0] q_wdata;
    logic [MEM_W-1:0] clr_idx;
    logic             fill_way;

    logic [NUM_LINES-1:0] line_valid;
    logic [BLK_W-1:0]     line_tag  [NUM_LINES];
    logic [DATA_W-1:0]    line_data [NUM_LINES][WORDS_PER_BLOCK];
    logic [DATA_W-1:0]    mem       [MEM_WORDS];

    logic [SET_W-1:0]  cur_set;
    logic [LINE_W-1:0] line0, line1, hit_line, fill_line;
    logic [1:0]        way_match;
    logic              victim_way, rnd_bit, hit_any, clr_last;
    logic [3:0]        bump;
    logic [3:0][CNT_W-1:0] counts;

    assign cur_set   = q_block[SET_W-1:0];
    assign line0     = {cur_set, 1'b0};
    assign line1     = {cur_set, 1'b1};
    assign hit_line  = {cur_set, way_match[1]};
    assign fill_line = {cur_set, fill_way};
    assign hit_any   = |way_match;
    assign clr_last  = (clr_idx == MEM_W'(MEM_WORDS - 1));
    assign req_ready = (state_q == ST_IDLE);

    wtc_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .rnd_bit(rnd_bit)
    );

    wtc_set_probe #(.BLK_W(BLK_W)) u_probe (
        .way_valid   ({line_valid[line1], line_valid[line0]}),
        .way0_tag    (line_tag[line0]),
        .way1_tag    (line_tag[line1]),
        .probe_block (q_block),
        .rnd_bit     (rnd_bit),
        .way_match   (way_match),
        .victim_way  (victim_way)
    );

    always_comb begin
        bump    = '0;
        bump[0] = (state_q == ST_LOOKUP) && !q_write &&  hit_any;
        bump[1] = (state_q == ST_LOOKUP) && !q_write && !hit_any;
        bump[2] = (state_q == ST_LOOKUP) &&  q_write &&  hit_any;
        bump[3] = (state_q == ST_LOOKUP) &&  q_write && !hit_any;
    end

    wtc_perf_counters #(.NUM_CNT(4), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .bump(bump), .count(counts)
    );

    assign cnt_rd_hit  = counts[0];
    assign cnt_rd_miss = counts[1];
    assign cnt_wr_hit  = counts[2];
    assign cnt_wr_miss = counts[3];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR:  if (clr_last) state_d = ST_IDLE;
            ST_IDLE:   if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = (!q_write && !hit_any) ? ST_FILL : ST_IDLE;
            ST_FILL:   state_d = ST_IDLE;
        endcase
    end

    // Control, tag and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_write    <= 1'b0;
            q_block    <= '0;
            q_off      <= '0;
            q_wdata    <= '0;
            clr_idx    <= '0;
            fill_way   <= 1'b0;
            line_valid <= '0;
            for (int l = 0; l < NUM_LINES; l++) line_tag[l] <= '0;
            resp_valid <= 1'b0;
            resp_data  <= '0;
            resp_hit   <= 1'b0;
        end else begin
            resp_valid <= 1'b0;
            unique case (state_q)
                ST_CLEAR: clr_idx <= clr_idx + MEM_W'(1);
                ST_IDLE: if (req_valid) begin
                    q_write <= req_write;
                    q_block <= req_block;
                    q_off   <= req_offset;
                    q_wdata <= req_wdata;
                end
                ST_LOOKUP: begin
                    if (q_write) begin
                        resp_valid <= 1'b1;
                        resp_data  <= q_wdata;
                        resp_hit   <= hit_any;
                    end else if (hit_any) begin
                        resp_valid <= 1'b1;
                        resp_data  <= line_data[hit_line][q_off];
                        resp_hit   <= 1'b1;
                    end else begin
                        fill_way <= victim_way;
                    end
                end
                ST_FILL: begin
                    line_valid[fill_line] <= 1'b1;
                    line_tag[fill_line]   <= q_block;
                    resp_valid <= 1'b1;
                    resp_data  <= mem[{q_block, q_off}];
                    resp_hit   <= 1'b0;
                end
            endcase
        end
    end

    // Storage arrays (no reset; the store is loaded by CLEAR)
    always_ff @(posedge clk) begin
        unique case (state_q)
            ST_CLEAR: mem[clr_idx] <= DATA_W'(clr_idx);
            ST_LOOKUP: if (q_write) begin
                mem[{q_block, q_off}] <= q_wdata;
                if (hit_any) line_data[hit_line][q_off] <= q_wdata;
            end
            ST_FILL: for (int w = 0; w < WORDS_PER_BLOCK; w++)
                line_data[fill_line][w] <= mem[{q_block, OFF_W'(w)}];
            default: ;
        endcase
    end

    // R10: ready drops right after an accept
    assert_ready_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R10: response is a single-cycle pulse
    assert_resp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);
    // R5: never two matching ways in one set
    assert_single_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP) |-> !(&way_match));
    // R6: an empty way 0 is always used first
    assert_first_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && !line_valid[line0]) |-> (fill_way == 1'b0));
    // R3: a fill leaves the line valid and tagged with the block
    assert_fill_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |=> (line_valid[$past(fill_line)] &&
                                  line_tag[$past(fill_line)] == $past(q_block)));
    // R7: every write reaches the store
    assert_write_through_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && q_write) |=>
            (mem[$past({q_block, q_off})] == $past(q_wdata)));
endmodule

// File: tb/wt_cache_2way_tb.sv
`timescale 1ns/1ps
module wt_cache_2way_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [3:0]  req_block = '0;
    logic [3:0]  req_offset = '0;
    logic [15:0] req_wdata = '0;
    logic        resp_valid;
    logic [15:0] resp_data;
    logic        resp_hit;
    logic [15:0] cnt_rd_hit, cnt_rd_miss, cnt_wr_hit, cnt_wr_miss;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    wt_cache_2way u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_block(req_block), .req_offset(req_offset), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_data(resp_data), .resp_hit(resp_hit),
        .cnt_rd_hit(cnt_rd_hit), .cnt_rd_miss(cnt_rd_miss),
        .cnt_wr_hit(cnt_wr_hit), .cnt_wr_miss(cnt_wr_miss)
    );

    typedef struct packed {
        logic        wr;
        logic [3:0]  blk;
        logic [3:0]  off;
        logic [15:0] wdata;
        logic [15:0] exp_data;
        logic        exp_hit;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd3,  4'd2,  16'd0,   16'd50,  1'b0},  // R3 cold miss
        '{1'b0, 4'd3,  4'd2,  16'd0,   16'd50,  1'b1},  // R4 hit
        '{1'b0, 4'd5,  4'd1,  16'd0,   16'd81,  1'b0},  // R2 set 1 way 0
        '{1'b0, 4'd1,  4'd0,  16'd0,   16'd16,  1'b0},  // R5 set 1 way 1
        '{1'b0, 4'd5,  4'd15, 16'd0,   16'd95,  1'b1},  // R5
        '{1'b0, 4'd1,  4'd7,  16'd0,   16'd23,  1'b1},  // R5
        '{1'b1, 4'd4,  4'd1,  16'd444, 16'd444, 1'b0},  // R8 write miss
        '{1'b0, 4'd4,  4'd1,  16'd0,   16'd444, 1'b0},  // R8 read after
        '{1'b1, 4'd4,  4'd3,  16'd777, 16'd777, 1'b1},  // R7 write hit
        '{1'b0, 4'd4,  4'd3,  16'd0,   16'd777, 1'b1},  // R7 read back
        '{1'b0, 4'd4,  4'd0,  16'd0,   16'd64,  1'b1},  // R4
        '{1'b0, 4'd12, 4'd1,  16'd0,   16'd193, 1'b0}   // R6 second way
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // One request; returns data, hit flag and edges from accept to response
    task automatic xfer(input logic wr, input logic [3:0] blk, input logic [3:0] off,
                        input logic [15:0] wd, output logic [15:0] d,
                        output logic h, output int lat);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_block = blk;
        req_offset = off; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 ready low after accept", int'(req_ready), 0);
        lat = 0;
        do begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end while (!resp_valid && lat < 10);
        d = resp_data;
        h = resp_hit;
        @(posedge clk);
        @(negedge clk);
        chk("R10 single response pulse", int'(resp_valid), 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [15:0] d;
        logic        h, h4, h12;
        int          lat, clr_cnt;

        repeat (3) @(negedge clk);
        chk("R1 counters zero in reset",
            int'(cnt_rd_hit + cnt_rd_miss + cnt_wr_hit + cnt_wr_miss), 0);
        rst_n = 1'b1;
        clr_cnt = 0;
        while (!req_ready && clr_cnt < 1000) begin
            @(posedge clk);
            @(negedge clk);
            clr_cnt++;
        end
        chk("R1 clear length", clr_cnt, 256);
        chk("R1 counters zero after clear",
            int'(cnt_rd_hit + cnt_rd_miss + cnt_wr_hit + cnt_wr_miss), 0);

        for (int i = 0; i < NV; i++) begin
            xfer(VECS[i].wr, VECS[i].blk, VECS[i].off, VECS[i].wdata, d, h, lat);
            chk($sformatf("R3/R4/R7/R8 data vec %0d", i), int'(d), int'(VECS[i].exp_data));
            chk($sformatf("R3/R4/R5 hit vec %0d", i), int'(h), int'(VECS[i].exp_hit));
            if (!VECS[i].wr)
                chk($sformatf("R3/R4 latency vec %0d", i), lat, VECS[i].exp_hit ? 1 : 2);
            else
                chk($sformatf("R10 write latency vec %0d", i), lat, 1);
        end
        chk("R9 read hits",   int'(cnt_rd_hit),  5);
        chk("R9 read misses", int'(cnt_rd_miss), 5);
        chk("R9 write hits",  int'(cnt_wr_hit),  1);
        chk("R9 write misses",int'(cnt_wr_miss), 1);

        // R6: set 0 full with blocks 4 and 12; block 0 evicts exactly one
        xfer(1'b0, 4'd0, 4'd0, 16'd0, d, h, lat);
        chk("R6 full-set miss data", int'(d), 0);
        chk("R6 full-set miss flag", int'(h), 0);
        xfer(1'b1, 4'd4, 4'd3, 16'd777, d, h4, lat);
        xfer(1'b1, 4'd12, 4'd1, 16'd193, d, h12, lat);
        chk("R6 exactly one former resident kept", int'(h4) + int'(h12), 1);
        xfer(1'b0, 4'd0, 4'd5, 16'd0, d, h, lat);
        chk("R6 new block resident", int'(h), 1);
        chk("R6 new block data", int'(d), 5);

        // R2: set 1 untouched by set 0 traffic
        xfer(1'b0, 4'd1, 4'd2, 16'd0, d, h, lat);
        chk("R2 block 1 still hits", int'(h), 1);
        chk("R2 block 1 data", int'(d), 18);
        xfer(1'b0, 4'd5, 4'd0, 16'd0, d, h, lat);
        chk("R2 block 5 still hits", int'(h), 1);
        chk("R2 block 5 data", int'(d), 80);

        // R5: block 9 shares set 1 but never aliases
        xfer(1'b0, 4'd9, 4'd0, 16'd0, d, h, lat);
        chk("R5 block 9 misses", int'(h), 0);
        chk("R5 block 9 data", int'(d), 144);

        chk("R9 final read hits",   int'(cnt_rd_hit),  8);
        chk("R9 final read misses", int'(cnt_rd_miss), 7);
        chk("R9 final write hits",  int'(cnt_wr_hit),  2);
        chk("R9 final write misses",int'(cnt_wr_miss), 2);

        finish_run();
    end
endmodule